// File: doc/BRIEF.md
# Serial Memory Control Register Guard

This block holds the one-byte control register of a serial memory supervisor. A bus front end, not part of this block, decodes the serial bus and passes on start conditions, stop conditions and addressed data-byte writes. The block decides, for each data byte, whether to acknowledge it. It applies accepted register writes when the stop arrives. It also tells the memory array whether a byte write to it is allowed.

Changes to the register go through write-enable latches. Both latches are volatile and both clear at reset. The nonvolatile fields hold the watchdog period, the protected block range and a sticky protect-enable bit. These fields change only after an exact unlock sequence: 02h, then 06h, then the new value, each in its own transaction that ends with a stop. A commit starts a busy period, a timer that stands in for the nonvolatile programming cycle. Reads are served straight from the register output. A start/stop pair that carries no data byte changes nothing.

The protected block range is checked on every array write. An attempted write into that range clears the register-write latch. When the write-protect pin is high and the protect-enable bit is set, the block range and the enable bit are frozen. Only the watchdog field can still be changed.

Top module: `ctlreg_guard`

## Requirements
- R1: After reset, `ctl_reg` reads 60h: watchdog field 11, protect code 000, protect-enable 0, both latches 0. `busy` is 0.
- R2: While the write-enable latch is 0, the only byte that is acknowledged is 02h written to the register address `REG_ADDR` (FFFFh). Every other register byte and every array byte is nacked, changes no state, and `arr_wr_ok` stays 0.
- R3: With the write-enable latch set and the register-write latch clear, the register accepts three bytes and nacks all others. 02h sets the write-enable latch (bit 1). 00h clears it. 06h sets both the write-enable latch and the register-write latch (bit 2). Each change takes effect at the stop and starts no busy period.
- R4: With the register-write latch set, a byte whose bits [2:1] are 01 is a commit, applied at the stop. The new fields come from the byte using the register layout: bit 7 protect-enable, bits 6:5 watchdog, bits 4:3 protect code bits 1:0, bit 0 protect code bit 2. The commit clears the register-write latch and raises `busy` for exactly `NV_CYCLES` cycles. The nonvolatile fields change at no other time.
- R5: With the register-write latch set, a byte whose bits [2:1] are 11 is acknowledged. It leaves every nonvolatile field unchanged and keeps the register-write latch set.
- R6: Only the first data byte after a start is considered. A second byte is nacked and cancels the whole pending register write. A repeated start with no stop in between also discards the pending write.
- R7: While `busy` is 1, every data byte is nacked and ignored.
- R8: A start/stop pair with no data byte (a register read) between unlock steps does not disturb the sequence.
- R9: Protect codes map to protected address ranges as follows:
  - 000 to 010: no range.
  - 011: `0` to `ARRAY_BYTES-1`.
  - 100 to 111: `0` to `PAGE_BYTES*2^(code-4)-1`.

  An array byte is acknowledged, with `arr_wr_ok` pulsed, if and only if the write-enable latch is set, `busy` is 0 and the address is outside the protected range.
- R10: An array write into the protected range is nacked and clears the register-write latch.
- R11: When `wp_pin` and protect-enable are both 1 at the stop, a commit updates only the watchdog field. The protect code and protect-enable keep their values.
- R12: `ack_vld` pulses for one cycle, in the cycle after each `wr_evt`. `ack` and `arr_wr_ok` are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | Start condition seen on the bus (one-cycle pulse) |
| stop_evt | input | 1 | Stop condition seen on the bus (one-cycle pulse) |
| wr_evt | input | 1 | A data byte was received (one-cycle pulse) |
| wr_addr | input | ADDR_W | Target address of the data byte |
| wr_data | input | 8 | Data byte value |
| wp_pin | input | 1 | Hardware write-protect pin |
| ctl_reg | output | 8 | Current control register value |
| ack_vld | output | 1 | Ack decision valid for the last data byte |
| ack | output | 1 | 1 = acknowledge, 0 = nack |
| busy | output | 1 | Nonvolatile cycle in progress |
| arr_wr_ok | output | 1 | Array write of the last byte is permitted |

## Verification
The assertions check on every cycle the properties that do not depend on history: a write is nacked while busy or before the write-enable latch is set, the nonvolatile fields move only at a stop, the register-write latch rises only at a stop, the hardware lock freezes the protect fields, and a byte that hits the protected range never yields a permit. Only the bench scenarios can show the ordering effects. These are the exact unlock sequence with reads in between, the abort on a second byte, the byte-by-byte acceptance tables, the exact length of the busy period, and the protected range of every protect code swept across the address space.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [2:0] {
    ACT_REJECT   = 3'd0,
    ACT_SET_WEL  = 3'd1,
    ACT_CLR_WEL  = 3'd2,
    ACT_SET_RWEL = 3'd3,
    ACT_COMMIT   = 3'd4,
    ACT_HOLD     = 3'd5
  } act_e;

  localparam logic [7:0] BYTE_WEL_ON  = 8'h02;
  localparam logic [7:0] BYTE_WEL_OFF = 8'h00;
  localparam logic [7:0] BYTE_UNLOCK  = 8'h06;

  // Top address (exclusive) of the protected range for a protect code.
  function automatic longint unsigned prot_limit(input int code,
                                                 input longint unsigned page,
                                                 input longint unsigned full);
    if (code == 3)      return full;
    else if (code >= 4) return page << (code - 4);
    else                return 0;
  endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
(
  input  logic [7:0] data,
  input  logic       wel,
  input  logic       rwel,
  output act_e       act
);
  always_comb begin
    act = ACT_REJECT;
    if (!wel) begin
      if (data == BYTE_WEL_ON) act = ACT_SET_WEL;
    end else if (!rwel) begin
      case (data)
        BYTE_WEL_ON:  act = ACT_SET_WEL;
        BYTE_WEL_OFF: act = ACT_CLR_WEL;
        BYTE_UNLOCK:  act = ACT_SET_RWEL;
        default:      act = ACT_REJECT;
      endcase
    end else begin
      if (data[2:1] == 2'b01)      act = ACT_COMMIT;
      else if (data[2:1] == 2'b11) act = ACT_HOLD;
      else if (data == BYTE_WEL_OFF) act = ACT_CLR_WEL;
    end
  end
endmodule

// File: rtl/ctlreg_nvtimer.sv
module ctlreg_nvtimer #(
  parameter int NV_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(NV_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load)       cnt_q <= LOADV;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);

  // R7: the busy count never exceeds the programmed cycle length
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOADV);
endmodule

// File: rtl/ctlreg_protect.sv
module ctlreg_protect
  import ctlreg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_BYTES = 4096,
  parameter int PAGE_BYTES  = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        code,
  output logic              hit
);
  localparam int LW = ADDR_W + 1;
  logic [7:0] hit_vec;

  for (genvar c = 0; c < 8; c++) begin : g_code
    localparam longint unsigned LIM = prot_limit(c, PAGE_BYTES, ARRAY_BYTES);
    localparam logic [LW-1:0]   LIMV = LW'(LIM);
    assign hit_vec[c] = ({1'b0, addr} < LIMV);
  end

  assign hit = hit_vec[code];
endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
  import ctlreg_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR  = '1,
  parameter int              ARRAY_BYTES = 4096,
  parameter int              PAGE_BYTES  = 64,
  parameter int              NV_CYCLES   = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wp_pin,
  output logic [7:0]        ctl_reg,
  output logic              ack_vld,
  output logic              ack,
  output logic              busy,
  output logic              arr_wr_ok
);
  // architectural state
  logic       wel_q, rwel_q, wpen_q;
  logic [1:0] wd_q;
  logic [2:0] bp_q;
  // transaction tracking
  logic       seen_q, abort_q, pend_v_q;
  act_e       pend_act_q;
  logic [7:0] pend_d_q;

  act_e dec_act;
  logic prot_hit, is_reg, hw_lock, commit_now;

  ctlreg_decode u_dec (
    .data (wr_data),
    .wel  (wel_q),
    .rwel (rwel_q),
    .act  (dec_act)
  );

  ctlreg_protect #(
    .ADDR_W      (ADDR_W),
    .ARRAY_BYTES (ARRAY_BYTES),
    .PAGE_BYTES  (PAGE_BYTES)
  ) u_prot (
    .addr (wr_addr),
    .code (bp_q),
    .hit  (prot_hit)
  );

  assign is_reg     = (wr_addr == REG_ADDR);
  assign hw_lock    = wp_pin & wpen_q;
  assign commit_now = stop_evt & !start_evt & pend_v_q & !abort_q &
                      (pend_act_q == ACT_COMMIT);

  ctlreg_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_nv (
    .clk  (clk),
    .rst  (rst),
    .load (commit_now),
    .busy (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      rwel_q     <= 1'b0;
      wpen_q     <= 1'b0;
      wd_q       <= 2'b11;
      bp_q       <= 3'b000;
      seen_q     <= 1'b0;
      abort_q    <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_act_q <= ACT_REJECT;
      pend_d_q   <= 8'h00;
      ack_vld    <= 1'b0;
      ack        <= 1'b0;
      arr_wr_ok  <= 1'b0;
    end else begin
      ack_vld   <= 1'b0;
      ack       <= 1'b0;
      arr_wr_ok <= 1'b0;
      if (start_evt) begin
        seen_q   <= 1'b0;
        abort_q  <= 1'b0;
        pend_v_q <= 1'b0;
      end else if (stop_evt) begin
        if (pend_v_q && !abort_q) begin
          case (pend_act_q)
            ACT_SET_WEL:  wel_q <= 1'b1;
            ACT_CLR_WEL:  wel_q <= 1'b0;
            ACT_SET_RWEL: begin
              wel_q  <= 1'b1;
              rwel_q <= 1'b1;
            end
            ACT_COMMIT: begin
              wd_q   <= pend_d_q[6:5];
              rwel_q <= 1'b0;
              if (!hw_lock) begin
                wpen_q <= pend_d_q[7];
                bp_q   <= {pend_d_q[0], pend_d_q[4:3]};
              end
            end
            default: ;
          endcase
        end
        seen_q   <= 1'b0;
        abort_q  <= 1'b0;
        pend_v_q <= 1'b0;
      end else if (wr_evt) begin
        ack_vld <= 1'b1;
        seen_q  <= 1'b1;
        if (is_reg) begin
          if (busy || seen_q) begin
            abort_q  <= 1'b1;
            pend_v_q <= 1'b0;
          end else if (dec_act != ACT_REJECT) begin
            ack        <= 1'b1;
            pend_v_q   <= 1'b1;
            pend_act_q <= dec_act;
            pend_d_q   <= wr_data;
          end
        end else if (!busy && wel_q) begin
          if (prot_hit) begin
            rwel_q <= 1'b0;
          end else begin
            ack       <= 1'b1;
            arr_wr_ok <= 1'b1;
          end
        end
      end
    end
  end

  assign ctl_reg = {wpen_q, wd_q, bp_q[1:0], rwel_q, wel_q, bp_q[2]};

  // R2: without the write-enable latch only the 02h register byte can be acked
  a_r2_locked_nack: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !start_evt && !stop_evt && !wel_q &&
     !(is_reg && wr_data == BYTE_WEL_ON)) |=> (ack_vld && !ack && !arr_wr_ok));

  // R7: every byte during the nonvolatile cycle is nacked
  a_r7_busy_nack: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !start_evt && !stop_evt && busy) |=> (ack_vld && !ack));

  // R4: nonvolatile fields move only when a stop is seen
  a_r4_fields_at_stop: assert property (@(posedge clk) disable iff (rst)
    !stop_evt |=> $stable({wpen_q, wd_q, bp_q}));

  // R3: the register-write latch can only rise at a stop
  a_r3_rwel_rise_at_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(rwel_q) |-> $past(stop_evt));

  // R11: hardware lock freezes protect code and enable bit
  a_r11_hw_lock: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && wp_pin && wpen_q) |=> ($stable(bp_q) && wpen_q));

  // R9: a byte inside the protected range never yields a permit
  a_r9_no_permit_in_range: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !start_evt && !stop_evt && !is_reg && prot_hit) |=> !arr_wr_ok);

  // R12: the ack decision appears exactly one cycle after a byte
  a_r12_ack_timing: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(wr_evt));
endmodule

// File: tb/ctlreg_guard_tb.sv
`timescale 1ns/1ps
module ctlreg_guard_tb;
  localparam int NV = 40;
  localparam logic [15:0] RA = 16'hFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_evt = 0, stop_evt = 0, wr_evt = 0, wp_pin = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  ctl_reg;
  logic ack_vld, ack, busy, arr_wr_ok;

  int n_chk = 0, n_fail = 0;
  logic g_vld, g_ack, g_ok;

  always #2.5 clk = ~clk;

  ctlreg_guard #(.NV_CYCLES(NV)) u_dut (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data), .wp_pin(wp_pin),
    .ctl_reg(ctl_reg), .ack_vld(ack_vld), .ack(ack), .busy(busy),
    .arr_wr_ok(arr_wr_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1;
    @(negedge clk) start_evt = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_evt = 1;
    @(negedge clk) stop_evt = 0;
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk) begin wr_evt = 1; wr_addr = a; wr_data = d; end
    @(negedge clk) begin
      wr_evt = 0;
      g_vld = ack_vld; g_ack = ack; g_ok = arr_wr_ok;
    end
  endtask

  // one complete transaction: start, one byte, stop
  task automatic txn(input logic [15:0] a, input logic [7:0] d);
    do_start();
    do_wr(a, d);
    do_stop();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] commit_byte(input logic wpen, input logic [1:0] wd,
                                             input logic [2:0] bp);
    return {wpen, wd, bp[1:0], 1'b0, 1'b1, bp[2]};
  endfunction

  function automatic logic is_prot(input int code, input int a);
    if (code == 3) return a < 4096;
    if (code >= 4) return a < (64 << (code - 4));
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl_reg", ctl_reg, 8'h60);
    chk("R1 busy", busy, 0);

    // R2 sweep: only 02h accepted while latch clear
    for (int d = 0; d < 256; d++) begin
      do_start();
      do_wr(RA, d[7:0]);
      chk("R2 ack", g_ack, d == 2);
      chk("R12 ack_vld", g_vld, 1);
    end
    do_start();
    do_wr(16'h0800, 8'hA5);
    chk("R2 array nack", {g_ack, g_ok}, 0);
    do_stop();
    chk("R2 state kept", ctl_reg, 8'h60);

    // R3 set WEL
    txn(RA, 8'h02);
    chk("R3 wel set", ctl_reg, 8'h62);
    chk("R3 no busy", busy, 0);
    for (int d = 0; d < 256; d++) begin
      do_start();
      do_wr(RA, d[7:0]);
      chk("R3 ack", g_ack, (d == 0) || (d == 2) || (d == 6));
    end
    do_start();
    chk("R3 state kept", ctl_reg, 8'h62);
    txn(RA, 8'h00);
    chk("R3 wel clear", ctl_reg, 8'h60);
    txn(RA, 8'h02);
    txn(RA, 8'h06);
    chk("R3 rwel set", ctl_reg, 8'h66);
    chk("R3 no busy after 06", busy, 0);

    // R5 / R4 acceptance sweep with register-write latch set
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b;
      b = d[7:0];
      do_start();
      do_wr(RA, b);
      chk("R4 R5 ack", g_ack, (b[2:1] == 2'b01) || (b[2:1] == 2'b11) || (b == 0));
    end
    do_start();
    chk("R5 state kept", ctl_reg, 8'h66);
    txn(RA, 8'hFE);
    chk("R5 hold", ctl_reg, 8'h66);
    chk("R5 no busy", busy, 0);

    // R4 commit and exact busy length
    txn(RA, 8'h3A);
    chk("R4 commit", ctl_reg, 8'h3A);
    begin
      int n;
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R4 busy length", n, NV);
    end

    // R9 protect range sweep for every code
    for (int c = 0; c < 8; c++) begin
      txn(RA, 8'h02);
      txn(RA, 8'h06);
      txn(RA, commit_byte(1'b0, 2'b11, c[2:0]));
      wait_idle();
      for (int a = 0; a < 8192; a += 64) begin
        for (int k = 0; k < 2; k++) begin
          int ad;
          ad = a + k * 63;
          do_start();
          do_wr(ad[15:0], 8'h55);
          chk("R9 ack", g_ack, !is_prot(c, ad));
          chk("R9 permit", g_ok, !is_prot(c, ad));
          do_stop();
        end
      end
    end

    // R10 protected attempt clears register-write latch (code 111 active)
    txn(RA, 8'h02);
    txn(RA, 8'h06);
    chk("R10 rwel before", ctl_reg[2], 1);
    txn(16'h0300, 8'h11);
    chk("R10 unprotected ok", g_ok, 1);
    chk("R10 rwel kept", ctl_reg[2], 1);
    txn(16'h0010, 8'h11);
    chk("R10 protected nack", g_ack, 0);
    chk("R10 rwel cleared", ctl_reg[2], 0);

    // R7 writes during busy
    txn(RA, 8'h06);
    txn(RA, commit_byte(1'b0, 2'b10, 3'b000));
    chk("R7 busy up", busy, 1);
    txn(RA, 8'h06);
    chk("R7 reg nack busy", g_ack, 0);
    txn(16'h1000, 8'h22);
    chk("R7 array nack busy", {g_ack, g_ok}, 0);
    chk("R7 ignored", ctl_reg, 8'h42);
    wait_idle();

    // R6 second byte aborts, repeated start discards
    do_start();
    do_wr(RA, 8'h00);
    chk("R6 first ack", g_ack, 1);
    do_wr(RA, 8'h06);
    chk("R6 second nack", g_ack, 0);
    do_stop();
    chk("R6 aborted", ctl_reg, 8'h42);
    do_start();
    do_wr(RA, 8'h00);
    do_start();
    do_stop();
    chk("R6 restart discard", ctl_reg, 8'h42);

    // R8 reads between unlock steps
    txn(RA, 8'h02);
    do_start(); do_stop();
    txn(RA, 8'h06);
    do_start(); do_stop();
    chk("R8 rwel survives read", ctl_reg, 8'h46);
    txn(RA, 8'h62);
    chk("R8 commit after reads", ctl_reg, 8'h62);
    wait_idle();

    // R11 hardware lock
    txn(RA, 8'h06);
    txn(RA, 8'hE3);
    chk("R11 wpen set", ctl_reg, 8'hE3);
    wait_idle();
    wp_pin = 1;
    txn(RA, 8'h06);
    txn(RA, 8'h02);
    chk("R11 only wd changes", ctl_reg, 8'h83);
    wait_idle();
    wp_pin = 0;
    txn(RA, 8'h06);
    txn(RA, 8'h02);
    chk("R11 unlocked when pin low", ctl_reg, 8'h02);
    wait_idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule